// File: doc/BRIEF.md
# Indirect Byte-Wide Register Port for a Video Output Controller

This block sits between an 8-bit microprocessor bus and the control registers of a video output stage. The processor never sees a flat address space. It first loads a 16-bit pointer one byte at a time, using a two-bit select code. It then uses a third select code to read or write the control register that the pointer names. The data bus is bidirectional. The block drives it only while the chip is enabled and the access is a read.

Every register has two copies. Each processor write lands in a shadow copy, and that copy is what read-back returns. The video side sees a separate live copy. The live copy is reloaded from the shadow only on a frame-boundary pulse, so a write made in the middle of a line never changes the picture until the next frame starts. Five registers are implemented: two command registers and one gain-trim register for each colour channel. Every other pointer value is a reserved hole.

Top module: `mpu_reg_port`

## Requirements
- R1: With chip enable low and select 00, a write (rdWr=0) loads the pointer's low byte (bits 7:0) on the next rising clock edge. A read (rdWr=1) drives that low byte onto the data bus.
- R2: With select 01, a write loads pointer bits 15:8 and a read returns them.
- R3: All 16 pointer bits are stored and read back. Register decoding uses only pointer bits 10:0, so pointer 0xFC00 reaches the same register as 0x400.
- R4: Select 11 is reserved. A write with it changes no pointer bit and no register. A read with it returns 0x00.
- R5: Select 10 accesses the register at the pointer. Command register A is at decoded address 0x400. Its bit 6 is reserved: it always reads 1 and writes to it are ignored.
- R6: The red, green and blue gain registers are at decoded addresses 0x404, 0x405 and 0x406. Each is 8 bits and can be read and written.
- R7: Command register B is at decoded address 0x411. It is 8 bits and can be read and written.
- R8: At any other decoded address, a write changes nothing and a read returns 0x00.
- R9: A write updates the shadow copy at once. The live output ports change only on the rising edge where frameTick is 1, and they then take the shadow values held before that edge.
- R10: After reset the pointer is 0x0000, the gain registers and command register B are 0x00, and command register A is 0x40. The shadow and live copies all hold these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; accesses are sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Active-low chip enable |
| rdWr | input | 1 | 1 = read, 0 = write |
| sel | input | 2 | Access select: 00 pointer low byte, 01 pointer high byte, 10 register, 11 reserved |
| dataIo | inout | 8 | Bidirectional data bus |
| frameTick | input | 1 | Frame-boundary pulse that copies shadow registers to the live outputs |
| cmdAOut | output | 8 | Live command register A |
| cmdBOut | output | 8 | Live command register B |
| gainRedOut | output | 8 | Live red gain trim |
| gainGrnOut | output | 8 | Live green gain trim |
| gainBluOut | output | 8 | Live blue gain trim |

## Verification
The main path is exercised by walking one pointer across all five real registers, then through a reserved hole, then to an aliased pointer. Each register is written with a different byte, so any mis-decoded address returns the wrong value. Setting the gain registers in ascending order and reading them back out of order separates a correct index decode from one that only ever returns the most recent write. Reserved-select and reserved-address writes are followed by read-backs of the pointer and of a real register, which exposes any stray write enable. Output ports are compared before and after frame pulses to separate shadow state from live state.

// File: rtl/mrp_pkg.sv
`timescale 1ns/1ps
package mrp_pkg;
  localparam int DATA_W   = 8;
  localparam int PTR_W    = 16;
  localparam int DEC_W    = 11;
  localparam int NUM_GAIN = 3;
  localparam int GIDX_W   = $clog2(NUM_GAIN);

  localparam logic [DEC_W-1:0] CMDA_ADDR = 11'h400;
  localparam logic [DEC_W-1:0] CMDB_ADDR = 11'h411;
  localparam logic [DEC_W-1:0] GAIN_BASE = 11'h404;

  localparam int CMDA_RESV_BIT = 6;
  localparam logic [DATA_W-1:0] CMDA_RESV_MASK = DATA_W'(1) << CMDA_RESV_BIT;
  localparam logic [DATA_W-1:0] CMDA_RST = CMDA_RESV_MASK;

  localparam logic [1:0] SEL_PLO  = 2'b00;
  localparam logic [1:0] SEL_PHI  = 2'b01;
  localparam logic [1:0] SEL_REG  = 2'b10;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PLO, RD_PHI, RD_CMDA, RD_CMDB, RD_GAIN
  } rdSrcE;

  typedef struct packed {
    logic                wrPtrLo;
    logic                wrPtrHi;
    logic                wrCmdA;
    logic                wrCmdB;
    logic [NUM_GAIN-1:0] wrGain;
    rdSrcE               rdSrc;
    logic [GIDX_W-1:0]   gainIdx;
    logic                busOe;
  } strobeT;
endpackage

// File: rtl/mrp_ctrl.sv
`timescale 1ns/1ps
module mrp_ctrl
  import mrp_pkg::*;
(
  input  logic             ceN,
  input  logic             rdWr,
  input  logic [1:0]       sel,
  input  logic [DEC_W-1:0] decAddr,
  output strobeT           strobe
);
  logic isWr;
  logic isRd;
  logic hitCmdA;
  logic hitCmdB;
  logic [NUM_GAIN-1:0] hitGain;
  logic [GIDX_W-1:0]   hitIdx;

  assign isWr = !ceN && !rdWr;
  assign isRd = !ceN && rdWr;

  assign hitCmdA = (decAddr == CMDA_ADDR);
  assign hitCmdB = (decAddr == CMDB_ADDR);

  for (genvar g = 0; g < NUM_GAIN; g++) begin : gHit
    assign hitGain[g] = (decAddr == GAIN_BASE + DEC_W'(g));
  end

  always_comb begin
    hitIdx = '0;
    for (int g = 0; g < NUM_GAIN; g++) begin
      if (hitGain[g]) hitIdx = GIDX_W'(g);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSrc   = RD_ZERO;
    strobe.busOe   = isRd;
    strobe.gainIdx = hitIdx;
    case (sel)
      SEL_PLO: begin
        strobe.wrPtrLo = isWr;
        strobe.rdSrc   = RD_PLO;
      end
      SEL_PHI: begin
        strobe.wrPtrHi = isWr;
        strobe.rdSrc   = RD_PHI;
      end
      SEL_REG: begin
        strobe.wrCmdA = isWr && hitCmdA;
        strobe.wrCmdB = isWr && hitCmdB;
        strobe.wrGain = isWr ? hitGain : '0;
        if (hitCmdA)      strobe.rdSrc = RD_CMDA;
        else if (hitCmdB) strobe.rdSrc = RD_CMDB;
        else if (|hitGain) strobe.rdSrc = RD_GAIN;
        else              strobe.rdSrc = RD_ZERO;
      end
      default: strobe.rdSrc = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/mrp_datapath.sv
`timescale 1ns/1ps
module mrp_datapath
  import mrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              frameTick,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptrQ,
  output logic [DATA_W-1:0] cmdALive,
  output logic [DATA_W-1:0] cmdBLive,
  output logic [DATA_W-1:0] gainLive [NUM_GAIN]
);
  localparam int HALF = PTR_W / 2;

  logic [DATA_W-1:0] cmdASh;
  logic [DATA_W-1:0] cmdBSh;
  logic [DATA_W-1:0] gainSh [NUM_GAIN];
  logic [DATA_W-1:0] gainRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else begin
      if (strobe.wrPtrLo) ptrQ[HALF-1:0]     <= wrData;
      if (strobe.wrPtrHi) ptrQ[PTR_W-1:HALF] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdASh   <= CMDA_RST;
      cmdBSh   <= '0;
      cmdALive <= CMDA_RST;
      cmdBLive <= '0;
    end else begin
      if (strobe.wrCmdA) cmdASh <= (wrData & ~CMDA_RESV_MASK) | (CMDA_RST & CMDA_RESV_MASK);
      if (strobe.wrCmdB) cmdBSh <= wrData;
      if (frameTick) begin
        cmdALive <= cmdASh;
        cmdBLive <= cmdBSh;
      end
    end
  end

  for (genvar g = 0; g < NUM_GAIN; g++) begin : gGain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gainSh[g]   <= '0;
        gainLive[g] <= '0;
      end else begin
        if (strobe.wrGain[g]) gainSh[g] <= wrData;
        if (frameTick)        gainLive[g] <= gainSh[g];
      end
    end
  end

  always_comb begin
    gainRd = '0;
    for (int g = 0; g < NUM_GAIN; g++) begin
      if (strobe.gainIdx == GIDX_W'(g)) gainRd = gainSh[g];
    end
  end

  always_comb begin
    case (strobe.rdSrc)
      RD_PLO:  rdData = ptrQ[HALF-1:0];
      RD_PHI:  rdData = ptrQ[PTR_W-1:HALF];
      RD_CMDA: rdData = cmdASh;
      RD_CMDB: rdData = cmdBSh;
      RD_GAIN: rdData = gainRd;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/mpu_reg_port.sv
`timescale 1ns/1ps
module mpu_reg_port
  import mrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              rdWr,
  input  logic [1:0]        sel,
  inout  wire  [DATA_W-1:0] dataIo,
  input  logic              frameTick,
  output logic [DATA_W-1:0] cmdAOut,
  output logic [DATA_W-1:0] cmdBOut,
  output logic [DATA_W-1:0] gainRedOut,
  output logic [DATA_W-1:0] gainGrnOut,
  output logic [DATA_W-1:0] gainBluOut
);
  strobeT            strobe;
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] gainLive [NUM_GAIN];

  mrp_ctrl u_ctrl (
    .ceN     (ceN),
    .rdWr    (rdWr),
    .sel     (sel),
    .decAddr (ptrQ[DEC_W-1:0]),
    .strobe  (strobe)
  );

  mrp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .frameTick (frameTick),
    .wrData    (dataIo),
    .rdData    (rdData),
    .ptrQ      (ptrQ),
    .cmdALive  (cmdAOut),
    .cmdBLive  (cmdBOut),
    .gainLive  (gainLive)
  );

  assign dataIo     = strobe.busOe ? rdData : 'z;
  assign gainRedOut = gainLive[0];
  assign gainGrnOut = gainLive[1];
  assign gainBluOut = gainLive[2];
endmodule

// File: rtl/mrp_checker.sv
`timescale 1ns/1ps
module mrp_checker
  import mrp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              rdWr,
  input logic [1:0]        sel,
  input logic [DATA_W-1:0] dataIo,
  input logic              frameTick,
  input logic [PTR_W-1:0]  ptrQ,
  input logic [DATA_W-1:0] cmdAOut,
  input logic [DATA_W-1:0] cmdBOut,
  input logic [DATA_W-1:0] gainRedOut,
  input logic [DATA_W-1:0] gainGrnOut,
  input logic [DATA_W-1:0] gainBluOut
);
  p_ptr_lo_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !rdWr && sel == 2'b00) |=> ptrQ[7:0] == $past(dataIo));

  p_ptr_lo_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && rdWr && sel == 2'b00) |-> dataIo == ptrQ[7:0]);

  p_ptr_hi_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !rdWr && sel == 2'b01) |=> ptrQ[15:8] == $past(dataIo));

  p_resv_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && sel == 2'b11) |=> $stable(ptrQ));

  p_resv_sel_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && rdWr && sel == 2'b11) |-> dataIo == '0);

  p_cmda_resv_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdAOut[CMDA_RESV_BIT] == 1'b1);

  p_frame_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> ($stable(cmdAOut) && $stable(cmdBOut) && $stable(gainRedOut)
                    && $stable(gainGrnOut) && $stable(gainBluOut)));
endmodule

bind mpu_reg_port mrp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ceN        (ceN),
  .rdWr       (rdWr),
  .sel        (sel),
  .dataIo     (dataIo),
  .frameTick  (frameTick),
  .ptrQ       (ptrQ),
  .cmdAOut    (cmdAOut),
  .cmdBOut    (cmdBOut),
  .gainRedOut (gainRedOut),
  .gainGrnOut (gainGrnOut),
  .gainBluOut (gainBluOut)
);

// File: tb/sim_mpu_reg_port.sv
`timescale 1ns/1ps
module sim_mpu_reg_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1;
  logic       rdWr = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       frameTick = 1'b0;
  logic       tbDrv = 1'b0;
  logic [7:0] tbData = 8'h00;
  wire  [7:0] dataIo;
  logic [7:0] cmdAOut, cmdBOut, gainRedOut, gainGrnOut, gainBluOut;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  assign dataIo = tbDrv ? tbData : 'z;

  always #4 clk = ~clk;

  mpu_reg_port u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .rdWr(rdWr), .sel(sel),
    .dataIo(dataIo), .frameTick(frameTick),
    .cmdAOut(cmdAOut), .cmdBOut(cmdBOut),
    .gainRedOut(gainRedOut), .gainGrnOut(gainGrnOut), .gainBluOut(gainBluOut)
  );

  // entry: {isRead, sel[1:0], data[7:0], expected[7:0], requirement[3:0]}
  localparam int NV = 33;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'h00, 4'd1},   // R1 pointer low = 00
    {1'b0, 2'd1, 8'h04, 8'h00, 4'd2},   // R2 pointer high = 04
    {1'b0, 2'd2, 8'hA5, 8'h00, 4'd5},   // R5 write command A
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd5},   // R5 bit 6 forced to 1
    {1'b1, 2'd0, 8'h00, 8'h00, 4'd1},   // R1 read low
    {1'b1, 2'd1, 8'h00, 8'h04, 4'd2},   // R2 read high
    {1'b0, 2'd0, 8'h04, 8'h00, 4'd6},   // R6 point at red
    {1'b0, 2'd2, 8'h11, 8'h00, 4'd6},
    {1'b0, 2'd0, 8'h05, 8'h00, 4'd6},   // R6 green
    {1'b0, 2'd2, 8'h22, 8'h00, 4'd6},
    {1'b0, 2'd0, 8'h06, 8'h00, 4'd6},   // R6 blue
    {1'b0, 2'd2, 8'h33, 8'h00, 4'd6},
    {1'b1, 2'd2, 8'h00, 8'h33, 4'd6},
    {1'b0, 2'd0, 8'h05, 8'h00, 4'd6},
    {1'b1, 2'd2, 8'h00, 8'h22, 4'd6},
    {1'b0, 2'd0, 8'h04, 8'h00, 4'd6},
    {1'b1, 2'd2, 8'h00, 8'h11, 4'd6},
    {1'b0, 2'd0, 8'h11, 8'h00, 4'd7},   // R7 command B
    {1'b0, 2'd2, 8'h7E, 8'h00, 4'd7},
    {1'b1, 2'd2, 8'h00, 8'h7E, 4'd7},
    {1'b0, 2'd0, 8'h07, 8'h00, 4'd8},   // R8 reserved hole 0x407
    {1'b0, 2'd2, 8'hFF, 8'h00, 4'd8},
    {1'b1, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd1, 8'hFC, 8'h00, 4'd3},   // R3 pointer 0xFC00 aliases 0x400
    {1'b0, 2'd0, 8'h00, 8'h00, 4'd3},
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd3},
    {1'b1, 2'd1, 8'h00, 8'hFC, 4'd3},
    {1'b0, 2'd3, 8'h55, 8'h00, 4'd4},   // R4 reserved select write
    {1'b1, 2'd0, 8'h00, 8'h00, 4'd4},
    {1'b1, 2'd1, 8'h00, 8'hFC, 4'd4},
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd4},
    {1'b0, 2'd0, 8'h11, 8'h00, 4'd8},   // R8 command B untouched by hole write
    {1'b1, 2'd2, 8'h00, 8'h7E, 4'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; rdWr = 1'b0; sel = s; tbData = d; tbDrv = 1'b1;
    @(negedge clk);
    ceN = 1'b1; rdWr = 1'b1; tbDrv = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    tbDrv = 1'b0; ceN = 1'b0; rdWr = 1'b1; sel = s;
    #2;
    d = dataIo;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 cmdA", cmdAOut, 8'h40);
    check("R10 cmdB", cmdBOut, 8'h00);
    check("R10 red", gainRedOut, 8'h00);
    check("R10 grn", gainGrnOut, 8'h00);
    check("R10 blu", gainBluOut, 8'h00);
    busRead(2'd0, rd); check("R10 ptr lo", rd, 8'h00);
    busRead(2'd1, rd); check("R10 ptr hi", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[22]) begin
        busRead(v[21:20], rd);
        checks++;
        if (rd !== v[11:4]) begin
          failures++;
          $display("FAIL R%0d vector %0d actual=%02h expected=%02h", v[3:0], i, rd, v[11:4]);
        end
      end else begin
        busWrite(v[21:20], v[19:12]);
      end
    end

    // R9 live outputs still at reset values until a frame pulse
    check("R9 cmdA before frame", cmdAOut, 8'h40);
    check("R9 red before frame", gainRedOut, 8'h00);
    pulseFrame();
    check("R9 cmdA after frame", cmdAOut, 8'hE5);
    check("R9 cmdB after frame", cmdBOut, 8'h7E);
    check("R9 red after frame", gainRedOut, 8'h11);
    check("R9 grn after frame", gainGrnOut, 8'h22);
    check("R9 blu after frame", gainBluOut, 8'h33);

    // R9 mid-frame write held back; pointer still at 0x411
    busWrite(2'd2, 8'h01);
    repeat (3) @(negedge clk);
    check("R9 cmdB held mid-frame", cmdBOut, 8'h7E);
    busRead(2'd2, rd); check("R9 cmdB shadow", rd, 8'h01);
    pulseFrame();
    check("R9 cmdB next frame", cmdBOut, 8'h01);
    // R8 hole write never reached any live output
    check("R8 cmdA clean", cmdAOut, 8'hE5);
    // R5 attempt to clear reserved bit
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, 8'h04);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, rd); check("R5 resv bit kept", rd, 8'h40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule